// File: doc/BRIEF.md
# ECAM Configuration Access Translator

This block sits between a host memory port and a PCIe configuration request path. A host read or write that lands in a memory-mapped enhanced configuration window is decoded into a configuration descriptor. The bus, device, function and register numbers are taken straight from fixed address bit positions, so no translation window has to be reprogrammed for each access. Where the access goes depends on how far its bus is from the root bus of the programmed range. An access to the root bus becomes a local controller register access. An access to the bus directly below the root becomes a Type 0 configuration request. Any deeper bus becomes a Type 1 configuration request.

Four programmable words set up the block: the window base, the window size, the bus range and a region control word. Translation stays off until these are consistent. The base must lie on a 256 MiB boundary, the window must be large enough for every bus in the range, and the region must be enabled with shifted decoding turned on. An access the block cannot translate produces no request. Instead it gets a one-cycle error response that carries all-ones read data.

The block keeps a single request slot. While a request waits for the downstream side to accept it, the host side is held off.

Top module: `ecam_xlate`

## Requirements
- R1: After reset, h_ready is 1, rq_valid, loc_valid and h_err are 0, h_rdata is 0, and translation is off.
- R2: Translation is on only when all of these hold: control word bit 31 (region enable) is set; control word bit 28 (shift enable) is set; base bits [27:0] are zero; the last bus is not below the first bus; and the window size shifted right by 20 is at least last - first + 1. While translation is off, every accepted access is answered as in R7.
- R3: A configuration request carries bus = address [27:20], device = [19:15], function = [14:12] and register = [11:2]. The host byte enables, write flag and write data pass through unchanged.
- R4: An accepted access whose bus equals the first bus pulses loc_valid for one cycle, on the clock edge after acceptance. It carries loc_off = address [19:0] together with the write flag, byte enables and data, and it raises no request.
- R5: An accepted access to bus first + 1 raises a request with rq_type1 = 0.
- R6: An accepted access to a bus above first + 1, up to and including the last bus, raises a request with rq_type1 = 1.
- R7: An access is answered with h_err high for one cycle and h_rdata all ones, and with no request and no local access, in any of these cases: its bus lies outside [first, last]; its address bits [31:28] differ from those of the base; or translation is off.
- R8: rq_valid rises on the clock edge after acceptance. The request and its fields stay stable until rq_ready is seen high. h_ready is low while a request is held.
- R9: A programming write with prog_sel 0 (base), 1 (size in bytes), 2 (first bus in bits [7:0], last bus in bits [15:8]) or 3 (control word) takes effect for accesses accepted on any later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_we | input | 1 | Programming write strobe |
| prog_sel | input | 2 | Programming word select |
| prog_wdata | input | 32 | Programming write data |
| h_valid | input | 1 | Host access valid |
| h_ready | output | 1 | Host access ready |
| h_addr | input | 32 | Host byte address |
| h_we | input | 1 | Host write flag |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_err | output | 1 | One-cycle error response |
| h_rdata | output | 32 | Error read data, all ones with h_err |
| loc_valid | output | 1 | Local register access strobe |
| loc_we | output | 1 | Local write flag |
| loc_off | output | 20 | Local register byte offset |
| loc_be | output | 4 | Local byte enables |
| loc_wdata | output | 32 | Local write data |
| rq_valid | output | 1 | Configuration request valid |
| rq_ready | input | 1 | Configuration request accepted |
| rq_type1 | output | 1 | 0 for Type 0, 1 for Type 1 |
| rq_we | output | 1 | Request is a write |
| rq_bus | output | 8 | Bus number |
| rq_dev | output | 5 | Device number |
| rq_fn | output | 3 | Function number |
| rq_reg | output | 10 | Register (dword) number |
| rq_be | output | 4 | First-DW byte enables |
| rq_wdata | output | 32 | Write data |

## Verification
Every result is due exactly one clock edge after the edge that accepts the host access. The result is a local strobe, an error pulse or a raised request. A request then stays up for every edge on which rq_ready is low, and it clears on the edge after rq_ready is seen high. Programming writes count from the edge that stores them, so the first access affected is the next one accepted. The bench drives inputs on falling edges, and a behavioural model advances on the same rising edges as the design. The bench compares every output with the model on each falling edge. Directed accesses are also checked on the falling edge that follows their acceptance.

// File: rtl/ecam_pkg.sv
package ecam_pkg;
  // Address bit layout inside the configuration window
  localparam int REG_LSB   = 2;
  localparam int FN_LSB    = 12;
  localparam int FN_W      = 3;
  localparam int DEV_W     = 5;
  localparam int DEV_LSB   = FN_LSB + FN_W;
  localparam int BUS_SHIFT = DEV_LSB + DEV_W;   // one bus per 1 MiB
  localparam int REG_W     = FN_LSB - REG_LSB;
  localparam int LOC_W     = BUS_SHIFT;

  // Region control word bits
  localparam int CTRL_EN_BIT    = 31;
  localparam int CTRL_SHIFT_BIT = 28;

  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_SIZE  = 2'd1,
    SEL_BUSES = 2'd2,
    SEL_CTRL  = 2'd3
  } prog_sel_e;

  typedef enum logic [1:0] {
    RT_LOCAL = 2'd0,
    RT_CFG0  = 2'd1,
    RT_CFG1  = 2'd2,
    RT_ERR   = 2'd3
  } route_e;
endpackage

// File: rtl/ecam_regs.sv
// Window programming words and the qualification of translation.
module ecam_regs
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          prog_we,
  input  logic [1:0]                    prog_sel,
  input  logic [ADDR_W-1:0]             prog_wdata,
  output logic [ADDR_W-BUS_W-BUS_SHIFT-1:0] base_hi,
  output logic [BUS_W-1:0]              bus_first,
  output logic [BUS_W-1:0]              bus_last,
  output logic                          mode_on
);
  localparam int WIN_BITS = BUS_W + BUS_SHIFT;
  localparam int ROOM_W   = ADDR_W - BUS_SHIFT;

  prog_sel_e              sel;
  logic                   ld_base, ld_size, ld_bus, ld_ctrl;
  logic [ADDR_W-1:0]      base_q, base_d;
  logic [ROOM_W-1:0]      room_q, room_d;
  logic [BUS_W-1:0]       first_d, last_d;
  logic                   en_q, en_d, shift_q, shift_d;
  logic [BUS_W:0]         span;
  logic                   aligned, order_ok, room_ok;

  // Next-state: write decode with clock enables per word
  always_comb begin
    sel     = prog_sel_e'(prog_sel);
    ld_base = prog_we && (sel == SEL_BASE);
    ld_size = prog_we && (sel == SEL_SIZE);
    ld_bus  = prog_we && (sel == SEL_BUSES);
    ld_ctrl = prog_we && (sel == SEL_CTRL);

    base_d  = ld_base ? prog_wdata : base_q;
    room_d  = ld_size ? prog_wdata[ADDR_W-1:BUS_SHIFT] : room_q;
    first_d = ld_bus  ? prog_wdata[BUS_W-1:0] : bus_first;
    last_d  = ld_bus  ? prog_wdata[2*BUS_W-1:BUS_W] : bus_last;
    en_d    = ld_ctrl ? prog_wdata[CTRL_EN_BIT] : en_q;
    shift_d = ld_ctrl ? prog_wdata[CTRL_SHIFT_BIT] : shift_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      room_q    <= '0;
      bus_first <= '0;
      bus_last  <= '0;
      en_q      <= 1'b0;
      shift_q   <= 1'b0;
    end else begin
      base_q    <= base_d;
      room_q    <= room_d;
      bus_first <= first_d;
      bus_last  <= last_d;
      en_q      <= en_d;
      shift_q   <= shift_d;
    end
  end

  // Qualification: alignment, bus order, window room, control bits
  always_comb begin
    span     = {1'b0, bus_last} - {1'b0, bus_first} + (BUS_W+1)'(1);
    aligned  = (base_q[WIN_BITS-1:0] == '0);
    order_ok = (bus_last >= bus_first);
    room_ok  = (room_q >= ROOM_W'(span));
    mode_on  = en_q && shift_q && aligned && order_ok && room_ok;
  end

  assign base_hi = base_q[ADDR_W-1:WIN_BITS];
endmodule

// File: rtl/ecam_decode.sv
// Combinational address split and route choice.
module ecam_decode
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8
) (
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [ADDR_W-BUS_W-BUS_SHIFT-1:0] base_hi,
  input  logic [BUS_W-1:0]                  bus_first,
  input  logic [BUS_W-1:0]                  bus_last,
  input  logic                              mode_on,
  output route_e                            route,
  output logic [BUS_W-1:0]                  bus,
  output logic [DEV_W-1:0]                  dev,
  output logic [FN_W-1:0]                   fn,
  output logic [REG_W-1:0]                  regn,
  output logic [LOC_W-1:0]                  loc_off
);
  localparam int WIN_BITS = BUS_W + BUS_SHIFT;

  logic           hit, in_rng;
  logic [BUS_W:0] next_bus;

  always_comb begin
    bus      = addr[WIN_BITS-1:BUS_SHIFT];
    dev      = addr[BUS_SHIFT-1:DEV_LSB];
    fn       = addr[DEV_LSB-1:FN_LSB];
    regn     = addr[FN_LSB-1:REG_LSB];
    loc_off  = addr[LOC_W-1:0];

    hit      = (addr[ADDR_W-1:WIN_BITS] == base_hi);
    in_rng   = (bus >= bus_first) && (bus <= bus_last);
    next_bus = {1'b0, bus_first} + (BUS_W+1)'(1);

    if (!(mode_on && hit && in_rng))
      route = RT_ERR;
    else if (bus == bus_first)
      route = RT_LOCAL;
    else if ({1'b0, bus} == next_bus)
      route = RT_CFG0;
    else
      route = RT_CFG1;
  end
endmodule

// File: rtl/ecam_req_slot.sv
// Output registers: one request slot, local strobe and error pulse.
module ecam_req_slot
  import ecam_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  route_e              route,
  input  logic [BUS_W-1:0]    bus,
  input  logic [DEV_W-1:0]    dev,
  input  logic [FN_W-1:0]     fn,
  input  logic [REG_W-1:0]    regn,
  input  logic [LOC_W-1:0]    off,
  input  logic                we,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                rq_ready,
  output logic                rq_valid,
  output logic                rq_type1,
  output logic [BUS_W-1:0]    rq_bus,
  output logic [DEV_W-1:0]    rq_dev,
  output logic [FN_W-1:0]     rq_fn,
  output logic [REG_W-1:0]    rq_reg,
  output logic                loc_valid,
  output logic [LOC_W-1:0]    loc_off,
  output logic                x_we,
  output logic [DATA_W/8-1:0] x_be,
  output logic [DATA_W-1:0]   x_wdata,
  output logic                err
);
  localparam int BE_W = DATA_W / 8;

  logic              is_cfg, is_loc, ld_x;
  logic              rqv_d, loc_d, err_d;
  logic              type1_d;
  logic [BUS_W-1:0]  bus_d;
  logic [DEV_W-1:0]  dev_d;
  logic [FN_W-1:0]   fn_d;
  logic [REG_W-1:0]  reg_d;
  logic [LOC_W-1:0]  off_d;
  logic              we_d;
  logic [BE_W-1:0]   be_d;
  logic [DATA_W-1:0] wdata_d;

  // Next-state
  always_comb begin
    is_cfg = acc && ((route == RT_CFG0) || (route == RT_CFG1));
    is_loc = acc && (route == RT_LOCAL);
    ld_x   = is_cfg || is_loc;

    if (is_cfg)                  rqv_d = 1'b1;
    else if (rq_valid && rq_ready) rqv_d = 1'b0;
    else                         rqv_d = rq_valid;
    loc_d = is_loc;
    err_d = acc && (route == RT_ERR);

    type1_d = is_cfg ? (route == RT_CFG1) : rq_type1;
    bus_d   = is_cfg ? bus  : rq_bus;
    dev_d   = is_cfg ? dev  : rq_dev;
    fn_d    = is_cfg ? fn   : rq_fn;
    reg_d   = is_cfg ? regn : rq_reg;
    off_d   = is_loc ? off  : loc_off;
    we_d    = ld_x ? we    : x_we;
    be_d    = ld_x ? be    : x_be;
    wdata_d = ld_x ? wdata : x_wdata;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_valid  <= 1'b0;
      loc_valid <= 1'b0;
      err       <= 1'b0;
      rq_type1  <= 1'b0;
      rq_bus    <= '0;
      rq_dev    <= '0;
      rq_fn     <= '0;
      rq_reg    <= '0;
      loc_off   <= '0;
      x_we      <= 1'b0;
      x_be      <= '0;
      x_wdata   <= '0;
    end else begin
      rq_valid  <= rqv_d;
      loc_valid <= loc_d;
      err       <= err_d;
      rq_type1  <= type1_d;
      rq_bus    <= bus_d;
      rq_dev    <= dev_d;
      rq_fn     <= fn_d;
      rq_reg    <= reg_d;
      loc_off   <= off_d;
      x_we      <= we_d;
      x_be      <= be_d;
      x_wdata   <= wdata_d;
    end
  end
endmodule

// File: rtl/ecam_xlate.sv
// Top: enhanced configuration window to configuration request translator.
module ecam_xlate
  import ecam_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                prog_we,
  input  logic [1:0]          prog_sel,
  input  logic [ADDR_W-1:0]   prog_wdata,
  input  logic                h_valid,
  output logic                h_ready,
  input  logic [ADDR_W-1:0]   h_addr,
  input  logic                h_we,
  input  logic [DATA_W/8-1:0] h_be,
  input  logic [DATA_W-1:0]   h_wdata,
  output logic                h_err,
  output logic [DATA_W-1:0]   h_rdata,
  output logic                loc_valid,
  output logic                loc_we,
  output logic [LOC_W-1:0]    loc_off,
  output logic [DATA_W/8-1:0] loc_be,
  output logic [DATA_W-1:0]   loc_wdata,
  output logic                rq_valid,
  input  logic                rq_ready,
  output logic                rq_type1,
  output logic                rq_we,
  output logic [BUS_W-1:0]    rq_bus,
  output logic [DEV_W-1:0]    rq_dev,
  output logic [FN_W-1:0]     rq_fn,
  output logic [REG_W-1:0]    rq_reg,
  output logic [DATA_W/8-1:0] rq_be,
  output logic [DATA_W-1:0]   rq_wdata
);
  localparam int BE_W   = DATA_W / 8;
  localparam int BASE_W = ADDR_W - BUS_W - BUS_SHIFT;

  logic [BASE_W-1:0] base_hi;
  logic [BUS_W-1:0]  bus_first, bus_last;
  logic              mode_on;
  route_e            route;
  logic [BUS_W-1:0]  d_bus;
  logic [DEV_W-1:0]  d_dev;
  logic [FN_W-1:0]   d_fn;
  logic [REG_W-1:0]  d_reg;
  logic [LOC_W-1:0]  d_off;
  logic              acc;
  logic              x_we;
  logic [BE_W-1:0]   x_be;
  logic [DATA_W-1:0] x_wdata;

  ecam_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_we    (prog_we),
    .prog_sel   (prog_sel),
    .prog_wdata (prog_wdata),
    .base_hi    (base_hi),
    .bus_first  (bus_first),
    .bus_last   (bus_last),
    .mode_on    (mode_on)
  );

  ecam_decode #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
    .addr      (h_addr),
    .base_hi   (base_hi),
    .bus_first (bus_first),
    .bus_last  (bus_last),
    .mode_on   (mode_on),
    .route     (route),
    .bus       (d_bus),
    .dev       (d_dev),
    .fn        (d_fn),
    .regn      (d_reg),
    .loc_off   (d_off)
  );

  // The single slot blocks the host while a request waits
  assign h_ready = !rq_valid;
  assign acc     = h_valid && h_ready;

  ecam_req_slot #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .route     (route),
    .bus       (d_bus),
    .dev       (d_dev),
    .fn        (d_fn),
    .regn      (d_reg),
    .off       (d_off),
    .we        (h_we),
    .be        (h_be),
    .wdata     (h_wdata),
    .rq_ready  (rq_ready),
    .rq_valid  (rq_valid),
    .rq_type1  (rq_type1),
    .rq_bus    (rq_bus),
    .rq_dev    (rq_dev),
    .rq_fn     (rq_fn),
    .rq_reg    (rq_reg),
    .loc_valid (loc_valid),
    .loc_off   (loc_off),
    .x_we      (x_we),
    .x_be      (x_be),
    .x_wdata   (x_wdata),
    .err       (h_err)
  );

  // Write payload registers are shared by both outbound paths
  assign loc_we    = x_we;
  assign loc_be    = x_be;
  assign loc_wdata = x_wdata;
  assign rq_we     = x_we;
  assign rq_be     = x_be;
  assign rq_wdata  = x_wdata;
  assign h_rdata   = {DATA_W{h_err}};
endmodule

// File: rtl/ecam_xlate_chk.sv
module ecam_xlate_chk
  import ecam_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUS_W  = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                h_valid,
  input logic                h_ready,
  input logic                h_err,
  input logic                loc_valid,
  input logic                rq_valid,
  input logic                rq_ready,
  input logic                rq_type1,
  input logic                rq_we,
  input logic [BUS_W-1:0]    rq_bus,
  input logic [DEV_W-1:0]    rq_dev,
  input logic [FN_W-1:0]     rq_fn,
  input logic [REG_W-1:0]    rq_reg,
  input logic [DATA_W/8-1:0] rq_be,
  input logic [DATA_W-1:0]   rq_wdata
);
  // R8
  rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> rq_valid &&
      $stable({rq_type1, rq_we, rq_bus, rq_dev, rq_fn, rq_reg, rq_be, rq_wdata}));

  // R8
  rq_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rq_valid) |-> $past(h_valid && h_ready));

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready |=> !loc_valid && !h_err);

  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_valid, h_err, rq_valid}));

  // R4
  answer_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_valid && h_ready |=> loc_valid || h_err || rq_valid);

  // R7
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |-> $past(h_valid && h_ready));
endmodule

bind ecam_xlate ecam_xlate_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/ecam_xlate_tb.sv
module ecam_xlate_tb;
  logic        clk, rst_n;
  logic        prog_we;
  logic [1:0]  prog_sel;
  logic [31:0] prog_wdata;
  logic        h_valid, h_ready, h_we, h_err;
  logic [31:0] h_addr, h_wdata, h_rdata;
  logic [3:0]  h_be;
  logic        loc_valid, loc_we;
  logic [19:0] loc_off;
  logic [3:0]  loc_be;
  logic [31:0] loc_wdata;
  logic        rq_valid, rq_ready, rq_type1, rq_we;
  logic [7:0]  rq_bus;
  logic [4:0]  rq_dev;
  logic [2:0]  rq_fn;
  logic [9:0]  rq_reg;
  logic [3:0]  rq_be;
  logic [31:0] rq_wdata;

  int total = 0;
  int fails = 0;
  bit running = 0;
  bit done = 0;

  ecam_xlate u_dut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_base, m_size, m_ctrl;
  int          m_first, m_last;
  bit          m_rqv, m_type1, m_loc, m_err, m_we;
  int          m_bus, m_dev, m_fn, m_reg, m_off;
  logic [3:0]  m_be;
  logic [31:0] m_wdata;

  // 0 local, 1 type0, 2 type1, 3 error
  function automatic int classify(input logic [31:0] a);
    int b;
    bit on;
    b  = int'(a[27:20]);
    on = m_ctrl[31] && m_ctrl[28] && (m_base[27:0] == 28'd0) &&
         (m_last >= m_first) && (int'(m_size >> 20) >= (m_last - m_first + 1));
    if (!on || a[31:28] != m_base[31:28] || b < m_first || b > m_last) return 3;
    if (b == m_first) return 0;
    if (b == m_first + 1) return 1;
    return 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_base = 0; m_size = 0; m_ctrl = 0; m_first = 0; m_last = 0;
      m_rqv = 0; m_type1 = 0; m_loc = 0; m_err = 0; m_we = 0;
      m_bus = 0; m_dev = 0; m_fn = 0; m_reg = 0; m_off = 0;
      m_be = 0; m_wdata = 0;
    end else begin
      int k;
      bit acc;
      acc = h_valid && !m_rqv;
      k   = classify(h_addr);
      m_loc = 0;
      m_err = 0;
      if (m_rqv && rq_ready) m_rqv = 0;
      if (acc) begin
        if (k == 3) m_err = 1;
        else begin
          m_we = h_we; m_be = h_be; m_wdata = h_wdata;
          if (k == 0) begin
            m_loc = 1;
            m_off = int'(h_addr[19:0]);
          end else begin
            m_rqv = 1; m_type1 = (k == 2);
            m_bus = int'(h_addr[27:20]); m_dev = int'(h_addr[19:15]);
            m_fn  = int'(h_addr[14:12]); m_reg = int'(h_addr[11:2]);
          end
        end
      end
      if (prog_we) begin
        case (prog_sel)
          2'd0: m_base = prog_wdata;
          2'd1: m_size = prog_wdata;
          2'd2: begin m_first = int'(prog_wdata[7:0]); m_last = int'(prog_wdata[15:8]); end
          default: m_ctrl = prog_wdata;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && running) begin
      chk("R8 h_ready", 64'(h_ready), 64'(!m_rqv));
      chk("R8 rq_valid", 64'(rq_valid), 64'(m_rqv));
      chk("R4 loc_valid", 64'(loc_valid), 64'(m_loc));
      chk("R7 h_err", 64'(h_err), 64'(m_err));
      chk("R7 h_rdata", 64'(h_rdata), m_err ? 64'hFFFF_FFFF : 64'h0);
      if (m_rqv) begin
        chk("R5 R6 rq_type1", 64'(rq_type1), 64'(m_type1));
        chk("R3 rq_bus", 64'(rq_bus), 64'(m_bus));
        chk("R3 rq_dev", 64'(rq_dev), 64'(m_dev));
        chk("R3 rq_fn", 64'(rq_fn), 64'(m_fn));
        chk("R3 rq_reg", 64'(rq_reg), 64'(m_reg));
        chk("R3 rq_be", 64'(rq_be), 64'(m_be));
        chk("R3 rq_we", 64'(rq_we), 64'(m_we));
        chk("R3 rq_wdata", 64'(rq_wdata), 64'(m_wdata));
      end
      if (m_loc) begin
        chk("R4 loc_off", 64'(loc_off), 64'(m_off));
        chk("R4 loc_we", 64'(loc_we), 64'(m_we));
        chk("R4 loc_be", 64'(loc_be), 64'(m_be));
        chk("R4 loc_wdata", 64'(loc_wdata), 64'(m_wdata));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic prog(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    prog_we = 1'b1; prog_sel = s; prog_wdata = d;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  // Returns at the falling edge after the accepting rising edge
  task automatic access(input logic [31:0] a, input logic w,
                        input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    while (!h_ready) begin
      rq_ready = 1'b1;
      @(negedge clk);
    end
    h_valid = 1'b1; h_addr = a; h_we = w; h_be = be; h_wdata = d;
    @(negedge clk);
    h_valid = 1'b0;
  endtask

  function automatic int seen();
    if (loc_valid) return 0;
    if (rq_valid && !rq_type1) return 1;
    if (rq_valid && rq_type1) return 2;
    if (h_err) return 3;
    return 4;
  endfunction

  task automatic expect_kind(input string tag, input int k);
    chk(tag, 64'(seen()), 64'(k));
  endtask

  task automatic setup_std();
    prog(2'd0, 32'h3000_0000);
    prog(2'd1, 32'h0200_0000);     // 32 buses of room
    prog(2'd2, 32'h0000_2004);     // first 0x04, last 0x20
    prog(2'd3, 32'h9000_0000);
  endtask

  // ---------------- main sequence ----------------
  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_sel = 2'd0; prog_wdata = '0;
    h_valid = 1'b0; h_addr = '0; h_we = 1'b0; h_be = '0; h_wdata = '0;
    rq_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 h_ready", 64'(h_ready), 64'd1);
    chk("R1 rq_valid", 64'(rq_valid), 64'd0);
    chk("R1 loc_valid", 64'(loc_valid), 64'd0);
    chk("R1 h_err", 64'(h_err), 64'd0);
    chk("R1 h_rdata", 64'(h_rdata), 64'd0);
    running = 1;

    access(32'h3040_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R1 R2 disabled after reset", 3);

    setup_std();
    access(32'h3040_0A0C, 1'b0, 4'hF, 32'h0);
    expect_kind("R4 root bus local", 0);
    chk("R4 loc_off", 64'(loc_off), 64'h00A0C);

    access(32'h3059_A10C, 1'b1, 4'b0110, 32'hCAFE_F00D);
    expect_kind("R5 type0", 1);
    chk("R3 bus", 64'(rq_bus), 64'd5);
    chk("R3 dev", 64'(rq_dev), 64'd19);
    chk("R3 fn", 64'(rq_fn), 64'd2);
    chk("R3 reg", 64'(rq_reg), 64'h43);
    chk("R3 be", 64'(rq_be), 64'h6);
    chk("R3 wdata", 64'(rq_wdata), 64'hCAFE_F00D);

    // R8 hold under back-pressure
    @(negedge clk);
    rq_ready = 1'b0;
    access(32'h3100_8004, 1'b0, 4'h3, 32'h0);
    expect_kind("R6 type1", 2);
    repeat (3) @(negedge clk);
    chk("R8 held valid", 64'(rq_valid), 64'd1);
    chk("R8 host blocked", 64'(h_ready), 64'd0);
    chk("R8 held bus", 64'(rq_bus), 64'h10);
    rq_ready = 1'b1;
    @(negedge clk);
    chk("R8 released", 64'(rq_valid), 64'd0);
    chk("R8 host ready", 64'(h_ready), 64'd1);

    access(32'h3200_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R6 last bus", 2);
    access(32'h3210_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R7 above last", 3);
    chk("R7 rdata ones", 64'(h_rdata), 64'hFFFF_FFFF);
    access(32'h3030_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R7 below first", 3);
    access(32'h5050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R7 outside window", 3);

    // R2 qualification corners, R9 write timing
    prog(2'd3, 32'h8000_0000);
    access(32'h3050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R2 R9 shift bit clear", 3);
    prog(2'd3, 32'h1000_0000);
    access(32'h3050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R2 enable bit clear", 3);
    prog(2'd3, 32'h9000_0000);
    access(32'h3050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R9 re-enabled", 1);
    prog(2'd0, 32'h3010_0000);
    access(32'h3050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R2 unaligned base", 3);
    prog(2'd0, 32'h3000_0000);
    prog(2'd1, 32'h01C0_0000);
    access(32'h3050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R2 window too small", 3);
    prog(2'd1, 32'h01D0_0000);
    access(32'h3050_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R2 window exact fit", 1);
    prog(2'd2, 32'h0000_0304);
    access(32'h3040_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R2 last below first", 3);

    // full 256-bus range starting at bus 0
    prog(2'd1, 32'h1000_0000);
    prog(2'd2, 32'h0000_FF00);
    access(32'h3000_1000, 1'b1, 4'h1, 32'h11);
    expect_kind("R4 bus zero local", 0);
    access(32'h3010_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R5 bus one", 1);
    access(32'h3FF0_0000, 1'b0, 4'hF, 32'h0);
    expect_kind("R6 bus 255", 2);

    // mixed traffic against the model
    setup_std();
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = {(($urandom % 8) == 0) ? 4'h5 : 4'h3, 8'($urandom % 40), 20'($urandom)};
      rq_ready = 1'($urandom);
      access(a, 1'($urandom), 4'($urandom), $urandom);
      if (($urandom % 4) == 0) @(negedge clk);
    end
    rq_ready = 1'b1;
    repeat (4) @(negedge clk);

    running = 0;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule